// File: doc/BRIEF.md
# Processor trap entry sequencer

This block carries out the hardware half of entering a trap on a processor with rotating register windows. Three kinds of request come in: a reset request, a synchronous trap caused by the instruction in flight (with its trap type), and an asynchronous interrupt (with its own trap type). The sequencer also sees the current program counter pair, the trap-enable bit, the supervisor bit, the current window pointer and the upper base field of the trap base register. It picks at most one event per cycle. Reset comes first, then the synchronous trap, then the asynchronous interrupt.

When an event is taken, the outputs on the following cycle carry the updated machine state. Trap enable is cleared and the supervisor bit is copied into the previous-supervisor bit. The window pointer moves down by one with wraparound. A paired register-file write stores the return pair into two locals of the new window, the trap-type field is loaded, and the program counter pair is pointed at the vector. The status word itself is never saved. Every change is reversible, so a later return instruction can undo it. A synchronous trap that arrives while traps are disabled does not trap. It latches a sticky error-mode flag instead, which only a reset can clear.

Top module: `trap_entry_seq`

## Requirements
- R1: A reset request wins over any other request. On the next cycle the new PC is 0, the new nPC is 4, the trap type is RESET_TT (default 0), and a set error-mode flag is cleared.
- R2: When a synchronous and an asynchronous request arrive together with trap enable at 1, the synchronous one is taken and tt_o equals sync_tt.
- R3: For every taken trap, trap_taken_o and rf_we_o are 1 for exactly the one cycle after the request is sampled. In that cycle et_o is 0 and ps_o equals the s_i that was sampled.
- R4: The new window pointer cwp_o, also presented on rf_win_o, is cwp_i minus one modulo NWIN. An input of 0 gives NWIN-1, which is 7 by default.
- R5: A synchronous trap saves the faulting pair: rf_l1_o equals pc_i and rf_l2_o equals npc_i.
- R6: An asynchronous trap saves the next two instructions: rf_l1_o equals npc_i and rf_l2_o equals npc_i+4.
- R7: For a non-reset trap, tbr_o is {tba_i, tt, 4'b0000}: the trap type sits in bits 11:4 and the low 4 bits are zero. The new PC equals tbr_o and the new nPC equals tbr_o+4.
- R8: An asynchronous request while et_i is 0 is ignored. trap_taken_o and rf_we_o stay 0, and the held outputs (new PC, et_o) do not change.
- R9: A synchronous request while et_i is 0 takes no trap and writes nothing. It sets err_mode_o on the next cycle. The flag stays set, and synchronous and asynchronous requests are ignored, until a reset request or rst_n clears it.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset trap request |
| sync_req | input | 1 | Synchronous trap request |
| sync_tt | input | TT_W | Trap type of the synchronous request |
| async_req | input | 1 | Asynchronous interrupt request |
| async_tt | input | TT_W | Trap type of the interrupt |
| et_i | input | 1 | Current trap enable |
| s_i | input | 1 | Current supervisor bit |
| cwp_i | input | CWP_W | Current window pointer |
| pc_i | input | XLEN | Current PC |
| npc_i | input | XLEN | Current nPC |
| tba_i | input | XLEN-TT_W-4 | Upper base field of the trap base register |
| trap_taken_o | output | 1 | One-cycle pulse per taken trap |
| et_o | output | 1 | Updated trap enable |
| ps_o | output | 1 | Updated previous-supervisor bit |
| cwp_o | output | CWP_W | Updated window pointer |
| tt_o | output | TT_W | Trap type loaded |
| tbr_o | output | XLEN | Updated trap base register |
| new_pc_o | output | XLEN | Redirected PC |
| new_npc_o | output | XLEN | Redirected nPC |
| rf_we_o | output | 1 | Paired register-file write strobe |
| rf_win_o | output | CWP_W | Window that receives the save |
| rf_l1_o | output | XLEN | Value for the first local |
| rf_l2_o | output | XLEN | Value for the second local |
| err_mode_o | output | 1 | Sticky error-mode flag |

## Verification
A wrong priority decision appears on the next cycle as the wrong tt_o or a missing trap_taken_o pulse. A wrong window pointer or a wrong return pair shows up as rf_win_o or rf_l1_o/rf_l2_o values that differ from the modulo arithmetic in the same cycle as the pulse. A broken error-mode latch shows up later. It lets an interrupt through one cycle after the flag should have blocked it, or the flag is gone on a cycle with no reset request.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  typedef enum logic [2:0] {
    TK_NONE  = 3'd0,
    TK_RESET = 3'd1,
    TK_SYNC  = 3'd2,
    TK_ASYNC = 3'd3,
    TK_ERROR = 3'd4
  } take_kind_e;

  // window below the current one, with wraparound
  function automatic int unsigned win_below(int unsigned cur, int unsigned nwin);
    return (cur == 0) ? nwin - 1 : cur - 1;
  endfunction

  function automatic logic [63:0] step4(logic [63:0] a);
    return a + 64'd4;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_seq_pkg::*;
#(
  parameter int TT_W     = 8,
  parameter int RESET_TT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reset_req,
  input  logic            sync_req,
  input  logic [TT_W-1:0] sync_tt,
  input  logic            async_req,
  input  logic [TT_W-1:0] async_tt,
  input  logic            et_i,
  input  logic            err_mode,
  output take_kind_e      kind,
  output logic [TT_W-1:0] tt_sel
);

  logic sync_ok, async_ok;

  assign sync_ok  = sync_req && et_i && !err_mode;
  assign async_ok = async_req && et_i && !err_mode;

  always_comb begin
    kind   = TK_NONE;
    tt_sel = '0;
    if (reset_req) begin
      kind   = TK_RESET;
      tt_sel = TT_W'(RESET_TT);
    end else if (sync_req && !et_i && !err_mode) begin
      kind = TK_ERROR;
    end else if (sync_ok) begin
      kind   = TK_SYNC;
      tt_sel = sync_tt;
    end else if (async_ok) begin
      kind   = TK_ASYNC;
      tt_sel = async_tt;
    end
  end

  // R8
  et_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!et_i && !reset_req) |-> (kind != TK_SYNC && kind != TK_ASYNC));

  // R9
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_mode |-> (kind == TK_NONE || kind == TK_RESET));

  // R2
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && async_req && et_i && !err_mode && !reset_req) |-> (tt_sel == sync_tt));

endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TT_W  = 8,
  localparam int TBA_W = XLEN - TT_W - 4
) (
  input  take_kind_e       kind,
  input  logic [TT_W-1:0]  tt,
  input  logic [TBA_W-1:0] tba,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  npc,
  output logic [XLEN-1:0]  tbr_val,
  output logic [XLEN-1:0]  vec_pc,
  output logic [XLEN-1:0]  vec_npc,
  output logic [XLEN-1:0]  save_l1,
  output logic [XLEN-1:0]  save_l2
);

  logic [63:0] vec_step, npc_step;

  assign tbr_val  = {tba, tt, 4'b0000};
  assign vec_pc   = (kind == TK_RESET) ? '0 : tbr_val;
  assign vec_step = step4(64'(vec_pc));
  assign npc_step = step4(64'(npc));
  assign vec_npc  = vec_step[XLEN-1:0];

  always_comb begin
    if (kind == TK_ASYNC) begin
      save_l1 = npc;
      save_l2 = npc_step[XLEN-1:0];
    end else begin
      save_l1 = pc;
      save_l2 = npc;
    end
  end

endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TT_W  = 8,
  parameter int NWIN  = 8,
  localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  take_kind_e       kind,
  input  logic [TT_W-1:0]  tt,
  input  logic             s_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [XLEN-1:0]  tbr_val,
  input  logic [XLEN-1:0]  vec_pc,
  input  logic [XLEN-1:0]  vec_npc,
  input  logic [XLEN-1:0]  save_l1,
  input  logic [XLEN-1:0]  save_l2,
  output logic             trap_taken_o,
  output logic             et_o,
  output logic             ps_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [XLEN-1:0]  tbr_o,
  output logic [XLEN-1:0]  new_pc_o,
  output logic [XLEN-1:0]  new_npc_o,
  output logic             rf_we_o,
  output logic [CWP_W-1:0] rf_win_o,
  output logic [XLEN-1:0]  rf_l1_o,
  output logic [XLEN-1:0]  rf_l2_o,
  output logic             err_mode_o
);

  logic             take_any;
  logic [CWP_W-1:0] cwp_next;

  assign take_any = (kind == TK_RESET) || (kind == TK_SYNC) || (kind == TK_ASYNC);
  assign cwp_next = CWP_W'(win_below(32'(cwp_i), NWIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_taken_o <= 1'b0;
      et_o         <= 1'b0;
      ps_o         <= 1'b0;
      cwp_o        <= '0;
      tt_o         <= '0;
      tbr_o        <= '0;
      new_pc_o     <= '0;
      new_npc_o    <= '0;
      rf_we_o      <= 1'b0;
      rf_win_o     <= '0;
      rf_l1_o      <= '0;
      rf_l2_o      <= '0;
      err_mode_o   <= 1'b0;
    end else begin
      trap_taken_o <= take_any;
      rf_we_o      <= take_any;
      if (take_any) begin
        et_o      <= 1'b0;
        ps_o      <= s_i;
        cwp_o     <= cwp_next;
        rf_win_o  <= cwp_next;
        tt_o      <= tt;
        tbr_o     <= tbr_val;
        new_pc_o  <= vec_pc;
        new_npc_o <= vec_npc;
        rf_l1_o   <= save_l1;
        rf_l2_o   <= save_l2;
      end
      if (kind == TK_RESET) err_mode_o <= 1'b0;
      else if (kind == TK_ERROR) err_mode_o <= 1'b1;
    end
  end

  // R3
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_any |=> (trap_taken_o && rf_we_o && !et_o));

  // R4
  win_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken_o |-> (rf_win_o == cwp_o));

  // R7
  vec_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken_o |-> (new_npc_o == new_pc_o + XLEN'(4) && new_pc_o[3:0] == 4'b0000));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode_o && kind != TK_RESET) |=> err_mode_o);

  // R9
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == TK_ERROR) |=> (!rf_we_o && err_mode_o));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int TT_W     = 8,
  parameter int NWIN     = 8,
  parameter int RESET_TT = 0,
  localparam int CWP_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int TBA_W   = XLEN - TT_W - 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_req,
  input  logic             sync_req,
  input  logic [TT_W-1:0]  sync_tt,
  input  logic             async_req,
  input  logic [TT_W-1:0]  async_tt,
  input  logic             et_i,
  input  logic             s_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  npc_i,
  input  logic [TBA_W-1:0] tba_i,
  output logic             trap_taken_o,
  output logic             et_o,
  output logic             ps_o,
  output logic [CWP_W-1:0] cwp_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [XLEN-1:0]  tbr_o,
  output logic [XLEN-1:0]  new_pc_o,
  output logic [XLEN-1:0]  new_npc_o,
  output logic             rf_we_o,
  output logic [CWP_W-1:0] rf_win_o,
  output logic [XLEN-1:0]  rf_l1_o,
  output logic [XLEN-1:0]  rf_l2_o,
  output logic             err_mode_o
);

  take_kind_e      kind;
  logic [TT_W-1:0] tt_sel;
  logic [XLEN-1:0] tbr_val, vec_pc, vec_npc, save_l1, save_l2;

  trap_arbiter #(.TT_W(TT_W), .RESET_TT(RESET_TT)) arb_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
    .sync_req(sync_req), .sync_tt(sync_tt),
    .async_req(async_req), .async_tt(async_tt),
    .et_i(et_i), .err_mode(err_mode_o),
    .kind(kind), .tt_sel(tt_sel)
  );

  trap_target #(.XLEN(XLEN), .TT_W(TT_W)) tgt_i (
    .kind(kind), .tt(tt_sel), .tba(tba_i), .pc(pc_i), .npc(npc_i),
    .tbr_val(tbr_val), .vec_pc(vec_pc), .vec_npc(vec_npc),
    .save_l1(save_l1), .save_l2(save_l2)
  );

  trap_commit #(.XLEN(XLEN), .TT_W(TT_W), .NWIN(NWIN)) cmt_i (
    .clk(clk), .rst_n(rst_n), .kind(kind), .tt(tt_sel),
    .s_i(s_i), .cwp_i(cwp_i), .tbr_val(tbr_val),
    .vec_pc(vec_pc), .vec_npc(vec_npc),
    .save_l1(save_l1), .save_l2(save_l2),
    .trap_taken_o(trap_taken_o), .et_o(et_o), .ps_o(ps_o),
    .cwp_o(cwp_o), .tt_o(tt_o), .tbr_o(tbr_o),
    .new_pc_o(new_pc_o), .new_npc_o(new_npc_o),
    .rf_we_o(rf_we_o), .rf_win_o(rf_win_o),
    .rf_l1_o(rf_l1_o), .rf_l2_o(rf_l2_o), .err_mode_o(err_mode_o)
  );

endmodule

// File: tb/trap_entry_seq_tb_top.sv
module trap_entry_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int TT_W = 8;
  localparam int NWIN = 8;
  localparam int CWP_W = 3;
  localparam int TBA_W = XLEN - TT_W - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reset_req = 0, sync_req = 0, async_req = 0;
  logic [TT_W-1:0] sync_tt = '0, async_tt = '0;
  logic et_i = 0, s_i = 0;
  logic [CWP_W-1:0] cwp_i = '0;
  logic [XLEN-1:0] pc_i = '0, npc_i = '0;
  logic [TBA_W-1:0] tba_i = 20'hABCDE;

  logic trap_taken_o, et_o, ps_o, rf_we_o, err_mode_o;
  logic [CWP_W-1:0] cwp_o, rf_win_o;
  logic [TT_W-1:0] tt_o;
  logic [XLEN-1:0] tbr_o, new_pc_o, new_npc_o, rf_l1_o, rf_l2_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq #(.XLEN(XLEN), .TT_W(TT_W), .NWIN(NWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req),
    .sync_req(sync_req), .sync_tt(sync_tt),
    .async_req(async_req), .async_tt(async_tt),
    .et_i(et_i), .s_i(s_i), .cwp_i(cwp_i),
    .pc_i(pc_i), .npc_i(npc_i), .tba_i(tba_i),
    .trap_taken_o(trap_taken_o), .et_o(et_o), .ps_o(ps_o),
    .cwp_o(cwp_o), .tt_o(tt_o), .tbr_o(tbr_o),
    .new_pc_o(new_pc_o), .new_npc_o(new_npc_o),
    .rf_we_o(rf_we_o), .rf_win_o(rf_win_o),
    .rf_l1_o(rf_l1_o), .rf_l2_o(rf_l2_o), .err_mode_o(err_mode_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] exp_vec(input logic [TT_W-1:0] tt);
    return XLEN'(tba_i) * 32'd4096 + XLEN'(tt) * 32'd16;
  endfunction

  function automatic logic [XLEN-1:0] exp_win(input logic [CWP_W-1:0] c);
    return XLEN'((int'(c) + NWIN - 1) % NWIN);
  endfunction

  // drive at a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic fire(input logic rr, input logic sr, input logic [TT_W-1:0] st,
                      input logic ar, input logic [TT_W-1:0] at,
                      input logic et, input logic s, input logic [CWP_W-1:0] c,
                      input logic [XLEN-1:0] pc, input logic [XLEN-1:0] npc);
    reset_req = rr; sync_req = sr; sync_tt = st; async_req = ar; async_tt = at;
    et_i = et; s_i = s; cwp_i = c; pc_i = pc; npc_i = npc;
    @(negedge clk);
  endtask

  task automatic quiet();
    reset_req = 0; sync_req = 0; async_req = 0;
  endtask

  task automatic t_reset_state();
    chk("R10", "trap_taken", XLEN'(trap_taken_o), 0);
    chk("R10", "rf_we", XLEN'(rf_we_o), 0);
    chk("R10", "err_mode", XLEN'(err_mode_o), 0);
    chk("R10", "new_pc", new_pc_o, 0);
  endtask

  task automatic t_reset_req();
    fire(1, 1, 8'h33, 1, 8'h44, 1, 1, 3'd5, 32'h2000, 32'h2004);
    chk("R1", "trap_taken", XLEN'(trap_taken_o), 1);
    chk("R1", "new_pc", new_pc_o, 0);
    chk("R1", "new_npc", new_npc_o, 4);
    chk("R1", "tt", XLEN'(tt_o), 0);
    chk("R3", "et", XLEN'(et_o), 0);
    chk("R3", "ps", XLEN'(ps_o), 1);
    quiet();
  endtask

  task automatic t_sync();
    fire(0, 1, 8'h2A, 0, 8'h00, 1, 0, 3'd3, 32'h0000_1000, 32'h0000_1004);
    chk("R3", "trap_taken", XLEN'(trap_taken_o), 1);
    chk("R3", "rf_we", XLEN'(rf_we_o), 1);
    chk("R3", "ps", XLEN'(ps_o), 0);
    chk("R4", "cwp", XLEN'(cwp_o), exp_win(3'd3));
    chk("R4", "rf_win", XLEN'(rf_win_o), exp_win(3'd3));
    chk("R5", "l1", rf_l1_o, 32'h1000);
    chk("R5", "l2", rf_l2_o, 32'h1004);
    chk("R7", "tbr", tbr_o, exp_vec(8'h2A));
    chk("R7", "new_pc", new_pc_o, exp_vec(8'h2A));
    chk("R7", "new_npc", new_npc_o, exp_vec(8'h2A) + 4);
    quiet();
    @(negedge clk);
    chk("R3", "pulse ends", XLEN'(trap_taken_o), 0);
    chk("R3", "write ends", XLEN'(rf_we_o), 0);
  endtask

  task automatic t_async_wrap();
    fire(0, 0, 8'h00, 1, 8'h11, 1, 1, 3'd0, 32'h0000_4000, 32'h0000_4004);
    chk("R4", "cwp wrap", XLEN'(cwp_o), 7);
    chk("R6", "l1", rf_l1_o, 32'h4004);
    chk("R6", "l2", rf_l2_o, 32'h4008);
    chk("R7", "new_pc", new_pc_o, exp_vec(8'h11));
    chk("R3", "ps", XLEN'(ps_o), 1);
    quiet();
  endtask

  task automatic t_both();
    fire(0, 1, 8'h09, 1, 8'h1F, 1, 0, 3'd6, 32'h100, 32'h104);
    chk("R2", "tt", XLEN'(tt_o), 8'h09);
    chk("R2", "l1 sync pair", rf_l1_o, 32'h100);
    quiet();
  endtask

  task automatic t_async_masked();
    logic [XLEN-1:0] held_pc;
    @(negedge clk);
    held_pc = new_pc_o;
    fire(0, 0, 8'h00, 1, 8'h15, 0, 1, 3'd2, 32'h300, 32'h304);
    chk("R8", "trap_taken", XLEN'(trap_taken_o), 0);
    chk("R8", "rf_we", XLEN'(rf_we_o), 0);
    chk("R8", "new_pc held", new_pc_o, held_pc);
    chk("R8", "et held", XLEN'(et_o), 0);
    quiet();
  endtask

  task automatic t_error_mode();
    fire(0, 1, 8'h07, 0, 8'h00, 0, 1, 3'd1, 32'h500, 32'h504);
    chk("R9", "err_mode", XLEN'(err_mode_o), 1);
    chk("R9", "trap_taken", XLEN'(trap_taken_o), 0);
    chk("R9", "rf_we", XLEN'(rf_we_o), 0);
    quiet();
    fire(0, 1, 8'h08, 1, 8'h12, 1, 1, 3'd1, 32'h600, 32'h604);
    chk("R9", "blocked trap", XLEN'(trap_taken_o), 0);
    chk("R9", "still err", XLEN'(err_mode_o), 1);
    quiet();
    fire(1, 0, 8'h00, 0, 8'h00, 0, 1, 3'd1, 32'h700, 32'h704);
    chk("R1", "err cleared", XLEN'(err_mode_o), 0);
    chk("R1", "reset taken", XLEN'(trap_taken_o), 1);
    quiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_req();
    t_sync();
    t_async_wrap();
    t_both();
    t_async_masked();
    t_error_mode();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule